// File: doc/BRIEF.md
# Fractional time-of-day counter

This block keeps a running time of day: a seconds count, a nanoseconds count that wraps at one second, and a 32-bit sub-nanosecond fraction in units of 2^-32 ns. On every clock the time advances by a programmable step. The step has a whole-nanosecond part and a signed fraction. A signed frequency correction can be added to it, so software can steer the rate without changing the nominal period.

Software works with the block through small registers, each 16 bits wide. It stages a time value, then selects a function and fires it. The functions are load, frequency update, add, subtract and capture. A rising edge on the external event input fires the selected function in exactly the same way as software does, and it cannot be masked. A capture copies the current time into one of two banks. Each bank has a valid flag.

Top module: `tod_counter_top`

## Requirements
- R1: After `rst`, the registers read as follows. Control (address 0x00) reads 0. Function (0x01) reads 0x001C: no-op code 7 in bits 4:2, trigger bit 0 clear, phase bit 8 clear. Status (0x02) reads 0. Step whole-ns (0x03) reads `DEF_STEP_NS`, and both step fraction words (0x04 high, 0x05 low) read 0.
- R2: While control bit 0 (run) is 0, the counter holds zero and fired functions have no effect. Once run is set, counting starts from zero.
- R3: While running, each clock adds the effective step to the time. The effective step in 2^-32 ns units is whole_ns*2^32 + signed(step fraction) + signed(correction).
- R4: The nanosecond field stays below `NS_WRAP`. When it reaches or passes `NS_WRAP`, it wraps by `NS_WRAP` and adds one to seconds.
- R5: Writing the function register stores the code (bits 4:2) and the phase bit (bit 8). Bit 0 set fires the function once. Bit 0 always reads back as 0. A function fired at clock edge k takes effect at edge k+1.
- R6: Code 0 replaces the time with the staged seconds, nanoseconds and fraction.
- R7: Code 1 copies the staged fraction into the signed frequency correction, which is used from the next clock onward.
- R8: Code 2 adds the staged value to the advanced time, carrying from fraction to nanoseconds and from nanoseconds to seconds.
- R9: Code 3 subtracts the staged value from the advanced time, borrowing from nanoseconds and from seconds.
- R10: Code 4 stores the time as it stands in that cycle. If bank 0 is empty, it goes to bank 0. Otherwise it goes to bank 1. Status bit 0 flags bank 0 and status bit 1 flags bank 1.
- R11: Reading a bank's low fraction word (0x16 for bank 0, 0x1E for bank 1) clears that bank's flag. A capture in the same cycle wins.
- R12: A rising edge on `ext_event`, sampled at a clock edge, fires the selected function exactly like bit 0 does. Code 7 changes nothing.
- R13: The staged value sits at 0x08..0x0E, bank 0 at 0x10..0x16 and bank 1 at 0x18..0x1E. Within each group the word order is: seconds high, middle and low, nanoseconds high and low, fraction high and low. Reads return data one clock after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| ext_event | input | 1 | External event, synchronous to clk, rising edge fires the function |

## Verification
The bench uses a small wrap of 1000 ns and sweeps loads that land at every offset just below the wrap. A design that compares with > instead of >=, or that forgets the seconds carry, shows a nanosecond value of 1000 or a missing second. Add and subtract are run with staged values that force a fraction carry, a nanosecond carry and a seconds borrow; a design that mishandles a carry or borrow ends up off by one nanosecond or one second. Back-to-back captures check which bank each capture fills and that each flag clears only on its own low-fraction read. Event edges with the no-op code and before run is set confirm that the time is not disturbed when nothing should happen.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    FN_LOAD = 3'd0,
    FN_FREQ = 3'd1,
    FN_ADD  = 3'd2,
    FN_SUB  = 3'd3,
    FN_CAPT = 3'd4,
    FN_IDLE = 3'd7
  } fn_e;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_FUNC    = 5'h01;
  localparam logic [ADDR_W-1:0] A_STAT    = 5'h02;
  localparam logic [ADDR_W-1:0] A_STEP_NS = 5'h03;
  localparam logic [ADDR_W-1:0] A_STEP_FH = 5'h04;
  localparam logic [ADDR_W-1:0] A_STEP_FL = 5'h05;

  localparam int TRIG_BIT  = 0;
  localparam int FN_LSB    = 2;
  localparam int PHASE_BIT = 8;
  localparam int GROUP_WORDS = 7;
  localparam int FR_LO_IDX = 6;
endpackage

// File: rtl/tod_regs.sv
module tod_regs import tod_pkg::*; #(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 30,
  parameter int FR_W        = 32,
  parameter int STEP_NS_W   = 16,
  parameter int DEF_STEP_NS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 ext_event,
  output logic                 run,
  output fn_e                  code,
  output logic                 fire,
  output logic [STEP_NS_W-1:0] step_ns,
  output logic [FR_W-1:0]      step_fr,
  output logic [SEC_W-1:0]     st_sec,
  output logic [NS_W-1:0]      st_ns,
  output logic [FR_W-1:0]      st_fr,
  output logic [DATA_W-1:0]    view
);
  logic                 phase_q;
  logic                 ev_q;
  logic [DATA_W-1:0]    step_hi_q, step_lo_q;
  logic [DATA_W-1:0]    stg [GROUP_WORDS];
  logic [3*DATA_W-1:0]  sec_cat;
  logic [2*DATA_W-1:0]  ns_cat, fr_cat, stepfr_cat;

  // staged load/adjust value, one register per 16-bit word
  for (genvar i = 0; i < GROUP_WORDS; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else if (wr && addr[4:3] == 2'b01 && addr[2:0] == 3'(i)) stg[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      code      <= FN_IDLE;
      phase_q   <= 1'b0;
      fire      <= 1'b0;
      ev_q      <= 1'b0;
      step_ns   <= STEP_NS_W'(DEF_STEP_NS);
      step_hi_q <= '0;
      step_lo_q <= '0;
    end else begin
      ev_q <= ext_event;
      fire <= (wr && addr == A_FUNC && wdata[TRIG_BIT]) || (ext_event && !ev_q);
      if (wr) begin
        case (addr)
          A_CTRL:    run <= wdata[0];
          A_FUNC: begin
            code    <= fn_e'(wdata[FN_LSB +: 3]);
            phase_q <= wdata[PHASE_BIT];
          end
          A_STEP_NS: step_ns   <= wdata[STEP_NS_W-1:0];
          A_STEP_FH: step_hi_q <= wdata;
          A_STEP_FL: step_lo_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign sec_cat    = {stg[0], stg[1], stg[2]};
  assign ns_cat     = {stg[3], stg[4]};
  assign fr_cat     = {stg[5], stg[6]};
  assign stepfr_cat = {step_hi_q, step_lo_q};
  assign st_sec  = sec_cat[SEC_W-1:0];
  assign st_ns   = ns_cat[NS_W-1:0];
  assign st_fr   = fr_cat[FR_W-1:0];
  assign step_fr = stepfr_cat[FR_W-1:0];

  always_comb begin
    view = '0;
    case (addr)
      A_CTRL:    view = DATA_W'(run);
      A_FUNC:    view = {7'b0, phase_q, 3'b0, code, 2'b0};
      A_STEP_NS: view = DATA_W'(step_ns);
      A_STEP_FH: view = step_hi_q;
      A_STEP_FL: view = step_lo_q;
      default:   if (addr[4:3] == 2'b01 && addr[2:0] != 3'd7) view = stg[addr[2:0]];
    endcase
  end

  // R12: an event edge always fires, nothing masks it
  assert_ext_fire_R12: assert property (@(posedge clk) disable iff (rst)
    (ext_event && !ev_q) |=> fire);
  // R5: the software trigger fires on the next cycle
  assert_sw_fire_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_FUNC && wdata[TRIG_BIT]) |=> fire);
endmodule

// File: rtl/tod_core.sv
module tod_core import tod_pkg::*; #(
  parameter int SEC_W     = 48,
  parameter int NS_W      = 30,
  parameter int FR_W      = 32,
  parameter int STEP_NS_W = 16,
  parameter int NS_WRAP   = 1_000_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 fire,
  input  fn_e                  code,
  input  logic [STEP_NS_W-1:0] step_ns,
  input  logic [FR_W-1:0]      step_fr,
  input  logic [SEC_W-1:0]     st_sec,
  input  logic [NS_W-1:0]      st_ns,
  input  logic [FR_W-1:0]      st_fr,
  output logic [SEC_W-1:0]     cur_sec,
  output logic [NS_W-1:0]      cur_ns,
  output logic [FR_W-1:0]      cur_fr,
  output logic                 cap_stb
);
  localparam int NSX   = NS_W + 2;
  localparam int INC_W = STEP_NS_W + FR_W + 1;
  localparam logic [NSX-1:0] WRAP_X = NSX'(NS_WRAP);

  logic [FR_W-1:0]  adj_q;
  logic [INC_W-1:0] inc;
  logic [FR_W:0]    fr_t, a_fr, s_fr;
  logic [NSX-1:0]   ns_t, t_ns, a_ns, s_ns;
  logic [SEC_W-1:0] t_sec;
  logic             wrap_t, a_wrap, s_neg;
  logic [SEC_W-1:0] n_sec;
  logic [NS_W-1:0]  n_ns;
  logic [FR_W-1:0]  n_fr;

  // effective step: whole ns plus signed fraction plus signed correction
  assign inc = {1'b0, step_ns, {FR_W{1'b0}}}
             + {{(INC_W-FR_W){step_fr[FR_W-1]}}, step_fr}
             + {{(INC_W-FR_W){adj_q[FR_W-1]}}, adj_q};

  // one clock of advance
  assign fr_t   = {1'b0, cur_fr} + {1'b0, inc[FR_W-1:0]};
  assign ns_t   = NSX'(cur_ns) + NSX'(inc[INC_W-1:FR_W]) + NSX'(fr_t[FR_W]);
  assign wrap_t = ns_t >= WRAP_X;
  assign t_ns   = wrap_t ? ns_t - WRAP_X : ns_t;
  assign t_sec  = cur_sec + SEC_W'(wrap_t);

  // add staged value to the advanced time
  assign a_fr   = {1'b0, fr_t[FR_W-1:0]} + {1'b0, st_fr};
  assign a_ns   = t_ns + NSX'(st_ns) + NSX'(a_fr[FR_W]);
  assign a_wrap = a_ns >= WRAP_X;

  // subtract staged value from the advanced time
  assign s_fr  = {1'b0, fr_t[FR_W-1:0]} - {1'b0, st_fr};
  assign s_ns  = t_ns - NSX'(st_ns) - NSX'(s_fr[FR_W]);
  assign s_neg = s_ns[NSX-1];

  assign cap_stb = run && fire && code == FN_CAPT;

  always_comb begin
    n_sec = t_sec;
    n_ns  = NS_W'(t_ns);
    n_fr  = fr_t[FR_W-1:0];
    if (fire) begin
      case (code)
        FN_LOAD: begin
          n_sec = st_sec;
          n_ns  = st_ns;
          n_fr  = st_fr;
        end
        FN_ADD: begin
          n_sec = t_sec + st_sec + SEC_W'(a_wrap);
          n_ns  = NS_W'(a_wrap ? a_ns - WRAP_X : a_ns);
          n_fr  = a_fr[FR_W-1:0];
        end
        FN_SUB: begin
          n_sec = t_sec - st_sec - SEC_W'(s_neg);
          n_ns  = NS_W'(s_neg ? s_ns + WRAP_X : s_ns);
          n_fr  = s_fr[FR_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cur_sec <= '0;
      cur_ns  <= '0;
      cur_fr  <= '0;
      adj_q   <= '0;
    end else begin
      cur_sec <= n_sec;
      cur_ns  <= n_ns;
      cur_fr  <= n_fr;
      if (fire && code == FN_FREQ) adj_q <= st_fr;
    end
  end

  assert_ns_range_R4: assert property (@(posedge clk) disable iff (rst)
    cur_ns < NS_W'(NS_WRAP));
  assert_sec_step_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !fire) |=> (cur_sec == $past(cur_sec) || cur_sec == $past(cur_sec) + 1'b1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cur_sec == '0 && cur_ns == '0 && cur_fr == '0));
  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    (run && fire && code == FN_LOAD) |=> (cur_ns == $past(st_ns) && cur_fr == $past(st_fr)));
endmodule

// File: rtl/tod_capture.sv
module tod_capture import tod_pkg::*; #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int FR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [NS_W-1:0]   cur_ns,
  input  logic [FR_W-1:0]   cur_fr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        valid,
  output logic [DATA_W-1:0] view
);
  localparam int FULL_W = GROUP_WORDS * DATA_W;

  logic [FULL_W-1:0] snap;
  logic [FULL_W-1:0] full_arr [2];

  assign snap = {(3*DATA_W)'(cur_sec), (2*DATA_W)'(cur_ns), (2*DATA_W)'(cur_fr)};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic              v_q;
    logic [FULL_W-1:0] full_q;
    logic              take, clr;
    assign take = cap && ((b == 0) ? !valid[0] : valid[0]);
    assign clr  = rd && addr[4] && addr[3] == 1'(b) && addr[2:0] == 3'(FR_LO_IDX);
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q    <= 1'b0;
        full_q <= '0;
      end else begin
        if (take) full_q <= snap;
        if (take) v_q <= 1'b1;
        else if (clr) v_q <= 1'b0;
      end
    end
    assign valid[b]    = v_q;
    assign full_arr[b] = full_q;
  end

  always_comb begin
    view = '0;
    if (addr[2:0] != 3'd7)
      view = full_arr[addr[3]][FULL_W-1 - DATA_W*addr[2:0] -: DATA_W];
  end

  assert_fill_first_R10: assert property (@(posedge clk) disable iff (rst)
    (cap && !valid[0]) |=> valid[0]);
  assert_fill_second_R10: assert property (@(posedge clk) disable iff (rst)
    (cap && valid[0]) |=> (valid[0] && valid[1]));
  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (!cap && rd && addr == 5'h16) |=> !valid[0]);
endmodule

// File: rtl/tod_counter_top.sv
module tod_counter_top import tod_pkg::*; #(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 30,
  parameter int FR_W        = 32,
  parameter int STEP_NS_W   = 16,
  parameter int NS_WRAP     = 1_000_000_000,
  parameter int DEF_STEP_NS = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ext_event
);
  logic                 run, fire, cap_stb;
  fn_e                  code;
  logic [STEP_NS_W-1:0] step_ns;
  logic [FR_W-1:0]      step_fr, st_fr, cur_fr;
  logic [SEC_W-1:0]     st_sec, cur_sec;
  logic [NS_W-1:0]      st_ns, cur_ns;
  logic [DATA_W-1:0]    reg_view, bank_view;
  logic [1:0]           valid;

  tod_regs #(.SEC_W(SEC_W), .NS_W(NS_W), .FR_W(FR_W), .STEP_NS_W(STEP_NS_W),
             .DEF_STEP_NS(DEF_STEP_NS)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ext_event(ext_event), .run(run), .code(code), .fire(fire),
    .step_ns(step_ns), .step_fr(step_fr), .st_sec(st_sec), .st_ns(st_ns),
    .st_fr(st_fr), .view(reg_view));

  tod_core #(.SEC_W(SEC_W), .NS_W(NS_W), .FR_W(FR_W), .STEP_NS_W(STEP_NS_W),
             .NS_WRAP(NS_WRAP)) u_core (
    .clk(clk), .rst(rst), .run(run), .fire(fire), .code(code),
    .step_ns(step_ns), .step_fr(step_fr), .st_sec(st_sec), .st_ns(st_ns),
    .st_fr(st_fr), .cur_sec(cur_sec), .cur_ns(cur_ns), .cur_fr(cur_fr),
    .cap_stb(cap_stb));

  tod_capture #(.SEC_W(SEC_W), .NS_W(NS_W), .FR_W(FR_W)) u_cap (
    .clk(clk), .rst(rst), .cap(cap_stb), .cur_sec(cur_sec), .cur_ns(cur_ns),
    .cur_fr(cur_fr), .rd(reg_rd), .addr(reg_addr), .valid(valid),
    .view(bank_view));

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      if (reg_addr == A_STAT) reg_rdata <= DATA_W'(valid);
      else if (reg_addr[4])   reg_rdata <= bank_view;
      else                    reg_rdata <= reg_view;
    end
  end

  assert_status_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_STAT) |=> reg_rdata == 16'($past(valid)));
endmodule

// File: tb/sim_tod_counter_top.sv
module sim_tod_counter_top;
  localparam int CLK_P = 10;
  localparam int WRAP  = 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0, ext = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tod_counter_top #(.NS_WRAP(WRAP), .DEF_STEP_NS(3)) u0 (
    .clk(clk), .rst(rst), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .ext_event(ext));

  // requirement-level model of the time register
  logic [127:0] mT, mb0, mb1;
  logic [1:0]   mv;
  logic [15:0]  m_sn;
  logic [31:0]  m_sf, m_adj;
  logic         m_run, pend, m_evq;
  logic [2:0]   m_code;
  logic [15:0]  ms [7];

  function automatic logic [127:0] tot(input logic [47:0] s, input logic [29:0] n,
                                       input logic [31:0] f);
    return ((128'(s) * WRAP + 128'(n)) << 32) + 128'(f);
  endfunction

  function automatic logic [15:0] word_of(input logic [127:0] t, input int i);
    logic [127:0] q, sec, ns;
    q = t >> 32; ns = q % WRAP; sec = q / WRAP;
    case (i)
      0: return sec[47:32];
      1: return sec[31:16];
      2: return sec[15:0];
      3: return ns[31:16];
      4: return ns[15:0];
      5: return t[31:16];
      default: return t[15:0];
    endcase
  endfunction

  task automatic model_edge(input bit w, input logic [4:0] a, input logic [15:0] d,
                            input bit r, input bit e);
    logic [127:0] inc, stg;
    inc = (128'(m_sn) << 32) + {{96{m_sf[31]}}, m_sf} + {{96{m_adj[31]}}, m_adj};
    stg = tot({ms[0], ms[1], ms[2]}, {ms[3][13:0], ms[4]}, {ms[5], ms[6]});
    if (r && a[4] && a[2:0] == 3'd6) mv[a[3]] = 1'b0;
    if (!m_run) begin mT = '0; m_adj = '0; end
    else if (pend) begin
      case (m_code)
        3'd0: mT = stg;
        3'd1: begin mT = mT + inc; m_adj = {ms[5], ms[6]}; end
        3'd2: mT = mT + inc + stg;
        3'd3: mT = mT + inc - stg;
        3'd4: begin
          if (!mv[0]) begin mb0 = mT; mv[0] = 1'b1; end
          else begin mb1 = mT; mv[1] = 1'b1; end
          mT = mT + inc;
        end
        default: mT = mT + inc;
      endcase
    end else mT = mT + inc;
    pend = (w && a == 5'h01 && d[0]) || (e && !m_evq);
    m_evq = e;
    if (w) begin
      case (a)
        5'h00: m_run = d[0];
        5'h01: m_code = d[4:2];
        5'h03: m_sn = d;
        5'h04: m_sf[31:16] = d;
        5'h05: m_sf[15:0] = d;
        default: if (a[4:3] == 2'b01 && a[2:0] != 3'd7) ms[a[2:0]] = d;
      endcase
    end
  endtask

  task automatic cyc(input bit w, input logic [4:0] a, input logic [15:0] d,
                     input bit r, input bit e);
    @(negedge clk);
    wr = w; addr = a; wdata = d; rd = r; ext = e;
    @(posedge clk);
    model_edge(w, a, d, r, e);
  endtask

  task automatic wreg(input logic [4:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'h00, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic rreg(input logic [4:0] a, output logic [15:0] v);
    cyc(1'b0, a, 16'h0, 1'b1, 1'b0);
    #(CLK_P/4);
    v = rdata;
  endtask

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stage(input logic [47:0] s, input logic [29:0] n, input logic [31:0] f);
    wreg(5'h08, s[47:32]); wreg(5'h09, s[31:16]); wreg(5'h0A, s[15:0]);
    wreg(5'h0B, 16'(n[29:16])); wreg(5'h0C, n[15:0]);
    wreg(5'h0D, f[31:16]); wreg(5'h0E, f[15:0]);
  endtask

  task automatic fire_code(input logic [2:0] c);
    wreg(5'h01, {11'b0, c, 2'b01});
  endtask

  task automatic check_bank(input int b, input string req);
    logic [127:0] snap;
    logic [15:0] v;
    snap = (b == 0) ? mb0 : mb1;
    for (int i = 0; i < 7; i++) begin
      rreg(5'(16 + 8*b + i), v);
      check(64'(v), 64'(word_of(snap, i)), req);
    end
  endtask

  task automatic check_status(input string req);
    logic [1:0] e;
    logic [15:0] v;
    e = mv;
    rreg(5'h02, v);
    check(64'(v), 64'(e), req);
  endtask

  task automatic ext_pulse();
    cyc(1'b0, 5'h00, 16'h0, 1'b0, 1'b1);
    cyc(1'b0, 5'h00, 16'h0, 1'b0, 1'b0);
  endtask

  initial begin
    logic [15:0] v;
    mT = '0; mb0 = '0; mb1 = '0; mv = '0; m_sn = 16'd3; m_sf = '0; m_adj = '0;
    m_run = 0; pend = 0; m_evq = 0; m_code = 3'd7;
    for (int i = 0; i < 7; i++) ms[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset values
    rreg(5'h00, v); check(64'(v), 64'h0, "R1 ctrl");
    rreg(5'h01, v); check(64'(v), 64'h001C, "R1 func");
    rreg(5'h02, v); check(64'(v), 64'h0, "R1 status");
    rreg(5'h03, v); check(64'(v), 64'd3, "R1 step");
    rreg(5'h05, v); check(64'(v), 64'h0, "R1 step frac");

    // R2 hold: capture and load before run are ignored
    fire_code(3'd4); idle(2);
    check_status("R2 capture ignored");
    stage(48'd7, 30'd500, 32'h1234_5678);
    fire_code(3'd0); idle(2);
    wreg(5'h00, 16'h1); idle(5);
    fire_code(3'd4); idle(1);
    check_status("R2 counting from zero");
    check_bank(0, "R2 start value");

    // R5 readback: trigger bit reads 0, phase and code kept; code 7 no effect
    wreg(5'h01, 16'h011D); idle(1);
    rreg(5'h01, v); check(64'(v), 64'h011C, "R5 func readback");
    check_status("R5 no-op");

    // R6 R13 load a full value then capture it at once
    stage(48'h0001_2345_6789, 30'd998, 32'h8000_0001);
    fire_code(3'd0); fire_code(3'd4); idle(1);
    check_bank(0, "R6 R13 load");

    // R3 R4 sweep across the nanosecond wrap
    for (int k = 0; k < 8; k++) begin
      stage(48'd40 + 48'(k), 30'(WRAP - 1 - k), 32'hC000_0000 + 32'(k));
      fire_code(3'd0); idle(k);
      fire_code(3'd4); idle(1);
      check_bank(0, "R4 wrap");
    end

    // R10 R11 two captures, fill order and clear on read
    fire_code(3'd4); idle(3); fire_code(3'd4); idle(1);
    check_status("R10 both valid");
    check_bank(1, "R10 bank1");
    check_status("R11 bank1 cleared");
    check_bank(0, "R10 bank0");
    check_status("R11 bank0 cleared");

    // R3 signed step fraction: 2 ns with MSB-set fraction means 1.75 ns
    wreg(5'h03, 16'd2); wreg(5'h04, 16'hC000); wreg(5'h05, 16'h0000);
    stage(48'd3, 30'd990, 32'h0);
    fire_code(3'd0); idle(9);
    fire_code(3'd4); idle(1);
    check_bank(0, "R3 fractional step");
    wreg(5'h03, 16'd3); wreg(5'h04, 16'h0); wreg(5'h05, 16'h0);

    // R7 frequency correction, positive then negative
    for (int k = 0; k < 2; k++) begin
      stage(48'd0, 30'd0, k == 0 ? 32'h4000_0000 : 32'hC000_0000);
      fire_code(3'd1); idle(6);
      fire_code(3'd4); idle(1);
      check_bank(0, "R7 correction");
    end
    stage(48'd0, 30'd0, 32'h0); fire_code(3'd1);

    // R8 add with fraction and nanosecond carries
    for (int k = 0; k < 3; k++) begin
      stage(48'd100, 30'd990, 32'hF000_0000);
      fire_code(3'd0);
      stage(48'd5 + 48'(k), 30'd15 + 30'(k), 32'h2000_0000);
      fire_code(3'd2); fire_code(3'd4); idle(1);
      check_bank(0, "R8 add");
    end

    // R9 subtract with fraction, nanosecond and second borrows
    for (int k = 0; k < 3; k++) begin
      stage(48'd200, 30'd5, 32'h1000_0000);
      fire_code(3'd0);
      stage(48'd3, 30'd900 + 30'(k), 32'h9000_0000);
      fire_code(3'd3); fire_code(3'd4); idle(1);
      check_bank(0, "R9 subtract");
    end

    // R12 external event: load and capture without the trigger bit, no-op code 7
    stage(48'd77, 30'd123, 32'h0000_4000);
    wreg(5'h01, 16'h0000); ext_pulse();
    wreg(5'h01, 16'h0010); ext_pulse(); idle(1);
    check_status("R12 event capture");
    check_bank(0, "R12 event load");
    wreg(5'h01, 16'h001C); ext_pulse(); ext_pulse();
    check_status("R12 no-op");
    fire_code(3'd4); idle(1);
    check_bank(0, "R12 time undisturbed");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule